// File: doc/BRIEF.md
# APM Command and Status Port Pair

This block provides two byte-wide registers on a small register bus, used by firmware and the operating system to hand power-management control back and forth. One address selects a command register and the other selects a status scratch register. Both registers read back the last byte written to them.

The block is built in one of two variants, selected by a parameter. In the default variant, every write to the command register raises a one-cycle request for a system-management interrupt. The handler that services the interrupt lives elsewhere. In the emulation variant, no interrupt is raised. Instead, the block decodes two command values itself and produces one-cycle set and clear strobes. These strobes drive the SCI-enable bit, which is held in a separate power-management control register outside this block.

Top module: `apm_cmd_port`

## Requirements
- R1: `sel_i` selects the register. `sel_i`=0 addresses the command register and `sel_i`=1 addresses the status register. `rdata_o` combinationally shows the register currently selected.
- R2: A write with `sel_i`=0 stores `wdata_i` into the command register. The new value appears on `rdata_o` from the cycle after the write edge.
- R3: A write with `sel_i`=1 stores `wdata_i` into the status register. It raises no pulse and leaves the command register unchanged.
- R4: With `EMUL_MODE`=0, every command write raises `smi_req_o` for exactly the cycle after the write edge, whatever the value written. Back-to-back writes give one high cycle per write. `smi_req_o` is never high otherwise.
- R5: With `EMUL_MODE`=0, `sci_set_o` and `sci_clr_o` stay low.
- R6: With `EMUL_MODE`=1, a command write of 0xF0 pulses `sci_clr_o` for one cycle after the write edge.
- R7: With `EMUL_MODE`=1, a command write of 0xF1 pulses `sci_set_o` for one cycle after the write edge.
- R8: With `EMUL_MODE`=1, `smi_req_o` stays low. Command values other than 0xF0 and 0xF1 are stored but produce no strobe.
- R9: While `rst_ni` is low, both registers are zero and all pulse outputs are low. No interrupt request follows reset.
- R10: While `wr_i` is low, neither register changes and no pulse is produced, whatever `sel_i` and `wdata_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the selected register |
| sel_i | input | 1 | Register select: 0 command, 1 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| smi_req_o | output | 1 | One-cycle interrupt request (default variant) |
| sci_set_o | output | 1 | One-cycle SCI-enable set strobe (emulation variant) |
| sci_clr_o | output | 1 | One-cycle SCI-enable clear strobe (emulation variant) |

## Verification
The hardest cases to reach are the boundary ones. One is a run of back-to-back command writes, where each pulse must last exactly one cycle and yet the output stays high for the whole run. The other is a write of 0xF0 or 0xF1 to the status register, which must not be mistaken for a command.

The stimulus drives directed bursts of alternating 0xF0/0xF1 command writes, plus status writes of the same codes. It then runs a long random sequence weighted toward those codes. Both variants are instantiated side by side, and each is compared every cycle against a behavioural model.

// File: rtl/apm_port_pkg.sv
package apm_port_pkg;
  localparam int unsigned APM_DW = 8;

  typedef enum logic {
    APM_SEL_CMD  = 1'b0,
    APM_SEL_STAT = 1'b1
  } apm_sel_e;

  typedef struct packed {
    logic smi;
    logic sci_set;
    logic sci_clr;
  } apm_evt_t;
endpackage

// File: rtl/apm_byte_reg.sv
module apm_byte_reg #(
  parameter int unsigned       W      = 8,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
  import apm_port_pkg::*;
#(
  parameter bit              EMUL_MODE = 1'b0,
  parameter int unsigned     W         = 8,
  parameter logic [W-1:0]    CODE_ON   = 8'hF1,
  parameter logic [W-1:0]    CODE_OFF  = 8'hF0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_we_i,
  input  logic [W-1:0] cmd_d_i,
  output apm_evt_t     evt_o
);
  apm_evt_t evt_d;

  always_comb begin
    evt_d = '0;
    if (cmd_we_i) begin
      if (EMUL_MODE) begin
        // firmware stand-in: act on enable/disable codes directly
        evt_d.sci_set = (cmd_d_i == CODE_ON);
        evt_d.sci_clr = (cmd_d_i == CODE_OFF);
      end else begin
        evt_d.smi = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= evt_d;
  end
endmodule

// File: rtl/apm_cmd_port.sv
module apm_cmd_port
  import apm_port_pkg::*;
#(
  parameter bit          EMUL_MODE = 1'b0,
  parameter int unsigned DW        = APM_DW,
  parameter logic [DW-1:0] CODE_ON  = 8'hF1,
  parameter logic [DW-1:0] CODE_OFF = 8'hF0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          smi_req_o,
  output logic          sci_set_o,
  output logic          sci_clr_o
);
  logic          cmd_we, stat_we;
  logic [DW-1:0] cmd_q, stat_q;
  apm_evt_t      evt;

  assign cmd_we  = wr_i && (apm_sel_e'(sel_i) == APM_SEL_CMD);
  assign stat_we = wr_i && (apm_sel_e'(sel_i) == APM_SEL_STAT);

  apm_byte_reg #(.W(DW)) u_cmd_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cmd_we), .d_i(wdata_i), .q_o(cmd_q)
  );

  apm_byte_reg #(.W(DW)) u_stat_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(stat_we), .d_i(wdata_i), .q_o(stat_q)
  );

  apm_cmd_decode #(
    .EMUL_MODE(EMUL_MODE), .W(DW), .CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)
  ) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we), .cmd_d_i(wdata_i), .evt_o(evt)
  );

  assign rdata_o   = (apm_sel_e'(sel_i) == APM_SEL_STAT) ? stat_q : cmd_q;
  assign smi_req_o = evt.smi;
  assign sci_set_o = evt.sci_set;
  assign sci_clr_o = evt.sci_clr;
endmodule

// File: rtl/apm_cmd_port_chk.sv
module apm_cmd_port_chk #(
  parameter bit          EMUL_MODE = 1'b0,
  parameter int unsigned DW        = 8,
  parameter logic [DW-1:0] CODE_ON  = 8'hF1,
  parameter logic [DW-1:0] CODE_OFF = 8'hF0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          sel_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] stat_q,
  input logic          smi_req_o,
  input logic          sci_set_o,
  input logic          sci_clr_o
);
  logic is_emul;
  assign is_emul = EMUL_MODE;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R9: assert (cmd_q == '0 && stat_q == '0 &&
                                     !smi_req_o && !sci_set_o && !sci_clr_o)
        else $error("reset state not clear");
    end
  end

  assert_cmd_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i) |=> (cmd_q == $past(wdata_i)));

  assert_stat_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i) |=> (stat_q == $past(wdata_i) && $stable(cmd_q)));

  assert_smi_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_emul && wr_i && !sel_i) |=> smi_req_o);

  assert_smi_only_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> $past(wr_i && !sel_i));

  assert_no_sci_smm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_emul |-> (!sci_set_o && !sci_clr_o));

  assert_clr_on_off_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_emul && wr_i && !sel_i && wdata_i == CODE_OFF) |=> (sci_clr_o && !sci_set_o));

  assert_set_on_on_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_emul && wr_i && !sel_i && wdata_i == CODE_ON) |=> (sci_set_o && !sci_clr_o));

  assert_no_smi_emul_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_emul |-> !smi_req_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(cmd_q) && $stable(stat_q) && !smi_req_o && !sci_set_o && !sci_clr_o));
endmodule

bind apm_cmd_port apm_cmd_port_chk #(
  .EMUL_MODE(EMUL_MODE), .DW(DW), .CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_i(sel_i), .wdata_i(wdata_i),
  .cmd_q(cmd_q), .stat_q(stat_q), .smi_req_o(smi_req_o),
  .sci_set_o(sci_set_o), .sci_clr_o(sci_clr_o)
);

// File: tb/apm_cmd_port_tb_top.sv
`timescale 1ns/1ps
module apm_cmd_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] wdata = 8'h00;

  logic [7:0] rd_s, rd_e;
  logic       smi_s, set_s, clr_s, smi_e, set_e, clr_e;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  apm_cmd_port #(.EMUL_MODE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .sel_i(sel), .wdata_i(wdata),
    .rdata_o(rd_s), .smi_req_o(smi_s), .sci_set_o(set_s), .sci_clr_o(clr_s)
  );

  apm_cmd_port #(.EMUL_MODE(1'b1)) dut_emu_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .sel_i(sel), .wdata_i(wdata),
    .rdata_o(rd_e), .smi_req_o(smi_e), .sci_set_o(set_e), .sci_clr_o(clr_e)
  );

  // behavioural reference, shared registers since both variants store identically
  int m_cmd, m_stat;
  bit m_smi, m_set, m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_stat = 0; m_smi = 0; m_set = 0; m_clr = 0;
    end else begin
      m_smi = wr && !sel;
      m_set = wr && !sel && wdata == 8'hF1;
      m_clr = wr && !sel && wdata == 8'hF0;
      if (wr && !sel) m_cmd  = wdata;
      if (wr &&  sel) m_stat = wdata;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the edge where inputs change
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check("R9 rdata smm", rd_s, 0);
        check("R9 rdata emu", rd_e, 0);
        check("R9 pulses", {smi_s, set_s, clr_s, smi_e, set_e, clr_e}, 0);
      end else begin
        check(sel ? "R3 stat smm" : "R2 cmd smm", rd_s, sel ? m_stat : m_cmd);
        check(sel ? "R3 stat emu" : "R2 cmd emu", rd_e, sel ? m_stat : m_cmd);
        check("R4 smi smm", smi_s, m_smi);
        check("R5 sci smm", {set_s, clr_s}, 0);
        check("R6 clr emu", clr_e, m_clr);
        check("R7 set emu", set_e, m_set);
        check("R8 smi emu", smi_e, 0);
      end
    end
  end

  task automatic drive(input bit w, input bit s, input logic [7:0] d);
    @(posedge clk); #2;
    wr = w; sel = s; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(2);

    // R1: address select, directed
    drive(1'b1, 1'b0, 8'h5A);
    drive(1'b1, 1'b1, 8'hA5);
    drive(1'b0, 1'b0, 8'h00);
    @(negedge clk); check("R1 sel0", rd_s, 8'h5A);
    drive(1'b0, 1'b1, 8'h00);
    @(negedge clk); check("R1 sel1", rd_e, 8'hA5);

    // R6 R7 back-to-back command codes, R4 sustained pulses
    drive(1'b1, 1'b0, 8'hF0);
    drive(1'b1, 1'b0, 8'hF1);
    drive(1'b1, 1'b0, 8'hF1);
    drive(1'b1, 1'b0, 8'hF0);
    drive(1'b1, 1'b0, 8'h00);
    drive(1'b1, 1'b0, 8'hFF);
    drive(1'b1, 1'b0, 8'hF2);
    idle(2);

    // R3: codes written to the status register must not strobe
    drive(1'b1, 1'b1, 8'hF0);
    drive(1'b1, 1'b1, 8'hF1);
    idle(1);
    @(negedge clk); check("R3 no strobe", {smi_s, set_e, clr_e}, 0);

    // R10: data and select toggling without a write
    for (int i = 0; i < 8; i++) drive(1'b0, i[0], 8'hF0 | 8'(i));
    @(negedge clk); check("R10 idle pulses", {smi_s, set_e, clr_e}, 0);
    drive(1'b0, 1'b1, 8'h33);
    @(negedge clk); check("R10 stat kept", rd_s, 8'hF1);

    // R9: reset in mid-run
    drive(1'b1, 1'b0, 8'h77);
    @(posedge clk); #2 rst_n = 1'b0; wr = 1'b0;
    idle(2);
    @(posedge clk); #2 rst_n = 1'b1;
    idle(1);
    @(negedge clk); check("R9 post-reset smi", smi_s, 0);

    // random phase weighted toward the two codes
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      logic [7:0] d = (r < 3) ? 8'hF0 : (r < 6) ? 8'hF1 : 8'($urandom);
      drive(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) == 0), d);
    end
    idle(3);
    finish_run();
  end
endmodule